// File: doc/BRIEF.md
# Sector Erase Accumulation Window Timer

This block sequences erase requests for a flash-like memory model. When a sector erase command arrives, the block does not start erasing at once. It marks the addressed sector in a selection bitmap and opens an acceptance window that is counted in microsecond ticks. Every further sector erase that arrives while the window is open adds its sector to the bitmap and restarts the full window. When a whole window passes with no new sector, the block raises its erase-started status bit, pulses a start strobe, and hands the bitmap to an erase engine. That status bit is the one software polls to see whether more sectors can still be queued.

A chip erase skips the window and starts the engine on the next cycle with every sector selected. Once an erase is running, every command except erase suspend is dropped until the engine reports completion. A suspend in that state is forwarded as a one-cycle request. An unrelated command that arrives while the window is open cancels the pending selection.

Top module: `erase_window_ctrl`

## Requirements
- R1: After reset, `erase_started`, `erase_go`, `suspend_req` and `erase_all` are 0 and `erase_map` is all zeros.
- R2: A sector erase command (`cmd_kind` = 0) in idle sets bit `cmd_sector` of `erase_map` on the next cycle. `erase_started` stays 0 while the window is open.
- R3: When `WIN_TICKS` ticks pass with no further sector erase, `erase_started` goes to 1 and `erase_go` is 1 for exactly one cycle, both seen on the cycle after the final tick.
- R4: Each sector erase command received while the window is open adds its sector to the map and restarts the full `WIN_TICKS` count. If a tick and a command fall in the same cycle, the command wins.
- R5: A chip erase command (`cmd_kind` = 1) in idle or during the window sets `erase_started`, `erase_all`, `erase_go` and an all-ones `erase_map` on the next cycle.
- R6: While `erase_started` is 1, sector erase, chip erase and other commands (`cmd_kind` = 3) leave `erase_map`, `erase_all` and `erase_started` unchanged.
- R7: An erase suspend command (`cmd_kind` = 2) while `erase_started` is 1 gives a one-cycle `suspend_req` on the next cycle. In any other state it has no effect.
- R8: `engine_done` while `erase_started` is 1 clears `erase_started`, `erase_all` and `erase_map` on the next cycle.
- R9: An other command during the window clears `erase_map` and returns to idle. No erase starts afterwards, however many ticks follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_us | input | 1 | One-cycle microsecond tick enable |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_kind | input | 2 | 0 sector erase, 1 chip erase, 2 erase suspend, 3 other |
| cmd_sector | input | SECT_W | Sector index for sector erase |
| engine_done | input | 1 | Erase engine completion pulse |
| erase_started | output | 1 | Status bit: 0 while idle or accumulating, 1 once erase runs |
| erase_go | output | 1 | One-cycle start strobe to the engine |
| erase_all | output | 1 | Running erase is a chip erase |
| erase_map | output | NSECT | Selected sectors handed to the engine |
| suspend_req | output | 1 | One-cycle suspend request to the engine |

## Verification
The assertions assume that `engine_done` is only pulsed while an erase is running, that `tick_us` is a single-cycle strobe, and that the command fields are stable whenever `cmd_valid` is high. They also assume that `cmd_sector` is always below `NSECT`, which the default power-of-two sector count guarantees. The stimulus drives each command, tick and done pulse for exactly one cycle and returns everything to zero between them. It raises `engine_done` only after the start has been observed.

// File: rtl/ewt_pkg.sv
package ewt_pkg;
  typedef enum logic [1:0] {
    CMD_SECTOR  = 2'd0,
    CMD_CHIP    = 2'd1,
    CMD_SUSPEND = 2'd2,
    CMD_OTHER   = 2'd3
  } ewt_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } ewt_state_e;
endpackage

// File: rtl/ewt_window_timer.sv
module ewt_window_timer #(
  parameter int WIN_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  localparam int CNT_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    expired = run && tick && !restart && (cnt_q == LAST);
    cnt_d   = cnt_q;
    if (!run || restart || expired) cnt_d = '0;
    else if (tick)                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/ewt_sector_map.sv
module ewt_sector_map #(
  parameter int NSECT  = 16,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [SECT_W-1:0] sector,
  input  logic              fill,
  input  logic              clear,
  output logic [NSECT-1:0]  map
);
  logic [NSECT-1:0] map_d;

  for (genvar i = 0; i < NSECT; i++) begin : g_bit
    always_comb begin
      map_d[i] = map[i];
      if (clear)                                      map_d[i] = 1'b0;
      else if (fill)                                  map_d[i] = 1'b1;
      else if (set_en && (sector == SECT_W'(i)))      map_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map <= '0;
    else        map <= map_d;
  end

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (map == '0));
endmodule

// File: rtl/ewt_seq_fsm.sv
module ewt_seq_fsm
  import ewt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_kind,
  input  logic       window_expired,
  input  logic       engine_done,
  output ewt_state_e state,
  output logic       erase_go,
  output logic       suspend_req,
  output logic       chip_mode,
  output logic       map_set,
  output logic       map_fill,
  output logic       map_clear,
  output logic       timer_restart
);
  ewt_state_e state_d;
  logic go_d, susp_d, chip_d;
  logic is_sector, is_chip, is_susp, is_other;

  always_comb begin
    is_sector = cmd_valid && (cmd_kind == CMD_SECTOR);
    is_chip   = cmd_valid && (cmd_kind == CMD_CHIP);
    is_susp   = cmd_valid && (cmd_kind == CMD_SUSPEND);
    is_other  = cmd_valid && (cmd_kind == CMD_OTHER);

    state_d       = state;
    go_d          = 1'b0;
    susp_d        = 1'b0;
    chip_d        = chip_mode;
    map_set       = 1'b0;
    map_fill      = 1'b0;
    map_clear     = 1'b0;
    timer_restart = 1'b0;

    unique case (state)
      ST_IDLE: begin
        if (is_chip) begin
          state_d  = ST_ERASE;
          map_fill = 1'b1;
          go_d     = 1'b1;
          chip_d   = 1'b1;
        end else if (is_sector) begin
          state_d       = ST_WINDOW;
          map_set       = 1'b1;
          timer_restart = 1'b1;
        end
      end
      ST_WINDOW: begin
        if (is_chip) begin
          state_d  = ST_ERASE;
          map_fill = 1'b1;
          go_d     = 1'b1;
          chip_d   = 1'b1;
        end else if (is_sector) begin
          map_set       = 1'b1;
          timer_restart = 1'b1;
        end else if (is_other) begin
          state_d   = ST_IDLE;
          map_clear = 1'b1;
        end else if (window_expired) begin
          state_d = ST_ERASE;
          go_d    = 1'b1;
        end
      end
      ST_ERASE: begin
        if (engine_done) begin
          state_d   = ST_IDLE;
          map_clear = 1'b1;
          chip_d    = 1'b0;
        end else if (is_susp) begin
          susp_d = 1'b1;
        end
      end
      default: begin
        state_d   = ST_IDLE;
        map_clear = 1'b1;
        chip_d    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      erase_go    <= 1'b0;
      suspend_req <= 1'b0;
      chip_mode   <= 1'b0;
    end else begin
      state       <= state_d;
      erase_go    <= go_d;
      suspend_req <= susp_d;
      chip_mode   <= chip_d;
    end
  end

  assert_go_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !erase_go);
  assert_go_in_erase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (state == ST_ERASE));
  assert_susp_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> ($past(state) == ST_ERASE));
  assert_other_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WINDOW && is_other) |=> (state == ST_IDLE));
endmodule

// File: rtl/erase_window_ctrl.sv
module erase_window_ctrl
  import ewt_pkg::*;
#(
  parameter int NSECT     = 16,
  parameter int WIN_TICKS = 50,
  parameter int SECT_W    = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic              engine_done,
  output logic              erase_started,
  output logic              erase_go,
  output logic              erase_all,
  output logic [NSECT-1:0]  erase_map,
  output logic              suspend_req
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  ewt_state_e state;
  logic expired, map_set, map_fill, map_clear, timer_restart;

  ewt_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .cmd_valid     (cmd_valid),
    .cmd_kind      (cmd_kind),
    .window_expired(expired),
    .engine_done   (engine_done),
    .state         (state),
    .erase_go      (erase_go),
    .suspend_req   (suspend_req),
    .chip_mode     (erase_all),
    .map_set       (map_set),
    .map_fill      (map_fill),
    .map_clear     (map_clear),
    .timer_restart (timer_restart)
  );

  ewt_window_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .run    (state == ST_WINDOW),
    .restart(timer_restart),
    .tick   (tick_us),
    .expired(expired)
  );

  ewt_sector_map #(.NSECT(NSECT), .SECT_W(SECT_W)) u_map (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set_en(map_set),
    .sector(cmd_sector),
    .fill  (map_fill),
    .clear (map_clear),
    .map   (erase_map)
  );

  assign erase_started = (state == ST_ERASE);

  assert_chip_immediate_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_valid && cmd_kind == CMD_CHIP && !erase_started)
      |=> (erase_started && erase_all && erase_go && (&erase_map)));
  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (erase_started && !engine_done)
      |=> (erase_started && $stable(erase_map) && $stable(erase_all)));
  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (erase_started && engine_done)
      |=> (!erase_started && !erase_all && erase_map == '0));
  assert_sector_no_start_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_valid && cmd_kind == CMD_SECTOR && !erase_started) |=> !erase_started);
endmodule

// File: tb/erase_window_ctrl_bench.sv
module erase_window_ctrl_bench;
  localparam int NS  = 16;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_us, cmd_valid, engine_done;
  logic [1:0] cmd_kind;
  logic [3:0] cmd_sector;
  logic erase_started, erase_go, erase_all, suspend_req;
  logic [NS-1:0] erase_map;

  always #4 clk = ~clk;

  erase_window_ctrl #(.NSECT(NS), .WIN_TICKS(WIN)) u_erase_window_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_sector(cmd_sector), .engine_done(engine_done),
    .erase_started(erase_started), .erase_go(erase_go), .erase_all(erase_all),
    .erase_map(erase_map), .suspend_req(suspend_req)
  );

  typedef struct {
    int          cyc;
    string       req;
    logic        st;
    logic [NS-1:0] map;
    logic        all;
    logic        go;
    logic        sp;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (erase_started !== e.st || erase_map !== e.map || erase_all !== e.all ||
          erase_go !== e.go || suspend_req !== e.sp) begin
        failures++;
        $display("FAIL %s cyc=%0d actual st=%b map=%h all=%b go=%b sp=%b expected st=%b map=%h all=%b go=%b sp=%b",
                 e.req, cyc, erase_started, erase_map, erase_all, erase_go, suspend_req,
                 e.st, e.map, e.all, e.go, e.sp);
      end
    end
  end

  task automatic drive(bit v, logic [1:0] k, int s, bit t, bit d);
    cmd_valid = v; cmd_kind = k; cmd_sector = 4'(s); tick_us = t; engine_done = d;
  endtask

  task automatic expect_next(string r, bit st, logic [NS-1:0] m, bit al, bit g, bit sp);
    exp_t e;
    e.cyc = cyc + 1; e.req = r; e.st = st; e.map = m; e.all = al; e.go = g; e.sp = sp;
    exp_q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
    drive(0, 2'd0, 0, 0, 0);
  endtask

  task automatic ticks(int n, string r, logic [NS-1:0] m);
    for (int i = 0; i < n; i++) begin
      drive(0, 2'd0, 0, 1, 0);
      expect_next(r, 0, m, 0, 0, 0);
      step();
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 2'd0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_next("R1", 0, '0, 0, 0, 0); step();

    // R2 sector 3 opens window
    drive(1, 2'd0, 3, 0, 0); expect_next("R2", 0, 16'h0008, 0, 0, 0); step();
    ticks(WIN - 1, "R2", 16'h0008);
    // R4 sector 5 restarts the count
    drive(1, 2'd0, 5, 0, 0); expect_next("R4", 0, 16'h0028, 0, 0, 0); step();
    ticks(WIN - 1, "R4", 16'h0028);
    // R3 final tick starts the erase
    drive(0, 2'd0, 0, 1, 0); expect_next("R3", 1, 16'h0028, 0, 1, 0); step();
    expect_next("R3", 1, 16'h0028, 0, 0, 0); step();

    // R6 commands ignored while erasing
    drive(1, 2'd0, 9, 0, 0); expect_next("R6", 1, 16'h0028, 0, 0, 0); step();
    drive(1, 2'd1, 0, 0, 0); expect_next("R6", 1, 16'h0028, 0, 0, 0); step();
    drive(1, 2'd3, 0, 1, 0); expect_next("R6", 1, 16'h0028, 0, 0, 0); step();

    // R7 suspend forwarded while erasing
    drive(1, 2'd2, 0, 0, 0); expect_next("R7", 1, 16'h0028, 0, 0, 1); step();
    expect_next("R7", 1, 16'h0028, 0, 0, 0); step();

    // R8 engine done clears
    drive(0, 2'd0, 0, 0, 1); expect_next("R8", 0, '0, 0, 0, 0); step();

    // R7 suspend in idle has no effect
    drive(1, 2'd2, 0, 0, 0); expect_next("R7", 0, '0, 0, 0, 0); step();

    // R9 other aborts the window
    drive(1, 2'd0, 1, 0, 0); expect_next("R9", 0, 16'h0002, 0, 0, 0); step();
    drive(1, 2'd3, 0, 0, 0); expect_next("R9", 0, '0, 0, 0, 0); step();
    ticks(WIN + 2, "R9", '0);

    // R5 chip erase from idle
    drive(1, 2'd1, 0, 0, 0); expect_next("R5", 1, 16'hFFFF, 1, 1, 0); step();
    drive(0, 2'd0, 0, 0, 1); expect_next("R8", 0, '0, 0, 0, 0); step();

    // R5 chip erase during the window
    drive(1, 2'd0, 2, 0, 0); expect_next("R2", 0, 16'h0004, 0, 0, 0); step();
    drive(1, 2'd1, 0, 0, 0); expect_next("R5", 1, 16'hFFFF, 1, 1, 0); step();
    drive(0, 2'd0, 0, 0, 1); expect_next("R8", 0, '0, 0, 0, 0); step();

    // R4 tick and command in the same cycle: command wins
    drive(1, 2'd0, 7, 0, 0); expect_next("R4", 0, 16'h0080, 0, 0, 0); step();
    ticks(WIN - 1, "R4", 16'h0080);
    drive(1, 2'd0, 0, 1, 0); expect_next("R4", 0, 16'h0081, 0, 0, 0); step();
    ticks(WIN - 1, "R4", 16'h0081);
    drive(0, 2'd0, 0, 1, 0); expect_next("R3", 1, 16'h0081, 0, 1, 0); step();

    step(); step();
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard left %0d items, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule